// File: doc/BRIEF.md
# Multi-mode 24-bit timer counter

This block is a memory-mapped 24-bit up-counter with three working behaviours and an off state, all chosen by a two-bit mode field in its control register. As an interval timer it counts up to compare value A. It then either clears to zero or stops there. As a pulse generator it toggles an output flip-flop at compare A and again at compare B, and B also clears the counter, so software sets both edges of a repeating waveform. As a watchdog it raises a flag when the counter reaches compare A. It keeps running even with its run bit low, unless software sets a separate stop bit.

The count source is either an internal tick enable or an external tick enable, each one clock cycle wide. The internal source can pass through a power-of-two prescaler. Software reaches the registers through a simple word bus: a write strobe with an address and data, and read data returned combinationally for the addressed word. An interrupt level output and the pulse flip-flop output go to the rest of the chip.

Top module: `mode_timer24`

## Requirements
- R1: After reset both compare registers read 0x00FFFFFF and every other register reads 0. This includes the counter at byte offset 0xF0. The interrupt output and the flip-flop output are both 0.
- R2: Word offsets are: control 0x00, status 0x04, compare A 0x08, compare B 0x0C, interval mode 0x10, divider 0x20, pulse mode 0x30, watchdog mode 0x40, counter 0xF0. Any other offset reads 0. Control bit 4 always reads 0. Compare registers keep only bits 23:0.
- R3: Mode 3 (control bits 1:0 = 3) never advances the counter. In modes 0 and 1 the counter advances only while the run bit (control bit 7) is 1.
- R4: Control bit 2 selects the count source: 0 = internal tick, 1 = external tick. The external tick is never divided. With the internal tick and control bit 6 set, the counter advances once per 2^(D+1) internal ticks, where D is divider bits 2:0.
- R5: In mode 0, when the counter reaches compare A, status bit 0 is set. If interval-mode bit 0 is 1, the counter returns to 0 on that step. If interval-mode bit 15 is 1, the interrupt output is raised.
- R6: In mode 0 with interval-mode bit 0 clear, the counter holds at compare A. The interrupt is raised only on the arrival step, not again while holding.
- R7: In mode 1, reaching compare A toggles the flip-flop and sets status bit 1. Reaching compare B toggles it again, sets status bit 2 and clears the counter to 0.
- R8: In mode 1, pulse-mode bit 14 enables the interrupt for the compare A event and bit 15 enables it for the compare B event. An event whose enable bit is clear sets its status bit but does not raise the interrupt.
- R9: In mode 2, reaching compare A sets status bit 3 and clears the counter. The interrupt is raised if watchdog-mode bit 15 is 1. The counter runs while the run bit is 0 unless watchdog-mode bit 7 is 1.
- R10: The interrupt output is a level. It stays high until software writes any value to the status register. That write clears all four status bits and lowers the interrupt.
- R11: A control write with bit 7 = 0 and bit 5 = 1 clears the counter to 0.
- R12: A write to the pulse-mode register loads the flip-flop output with bit 0 of the written data.
- R13: Any change to the clock select, the divider enable or the divider value restarts the prescaler from zero, so the new ratio counts from a clean start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| int_tick | input | 1 | Internal count enable, one cycle wide |
| ext_tick | input | 1 | External count enable, one cycle wide |
| irq_o | output | 1 | Interrupt level |
| ff_o | output | 1 | Pulse generator flip-flop output |

## Verification
The bench targets the interval hold case. There a design that keeps re-entering the compare event would raise the interrupt again after software cleared it, or would creep past compare A. It drives a prescaler ratio change in the middle of a count. A prescaler that kept its stale count would fire early or miss its terminal value and never fire. Pulse mode is run with only the A interrupt enabled, which exposes a design that ORs the two enables together. The watchdog is run with the run bit low, both with and without the stop bit, because getting that gate backwards either freezes a live watchdog or lets a stopped one expire.

// File: rtl/mode_timer24_pkg.sv
package mode_timer24_pkg;

  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_PULSE    = 2'd1,
    MODE_WDOG     = 2'd2,
    MODE_OFF      = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   run;
    logic   div_on;
    logic   clr_on;
    logic   spare3;
    logic   ext_sel;
    tmode_e mode;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CMPA   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CMPB   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_IVAL   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_DIV    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_PULSE  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_WDOG   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'hF0;

  // internal ticks per counter step when the prescaler is in use
  function automatic int unsigned prescale_span(input int unsigned d);
    return 32'd1 << (d + 1);
  endfunction

  // whether the selected mode lets the counter step this cycle
  function automatic logic mode_allows(input tmode_e m, input logic run,
                                       input logic at_a, input logic wd_hold);
    case (m)
      MODE_INTERVAL: return run && !at_a;
      MODE_PULSE:    return run;
      MODE_WDOG:     return run || !wd_hold;
      default:       return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mode_timer24_regs.sv
module mode_timer24_regs
  import mode_timer24_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [3:0]        status,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output logic              iv_irq_en,
  output logic              iv_zero_clr,
  output logic [DIV_W-1:0]  div_sel,
  output logic              pa_irq_en,
  output logic              pb_irq_en,
  output logic              ff_init,
  output logic              wd_irq_en,
  output logic              wd_hold,
  output logic              wd_spare,
  output logic [31:0]       bus_rdata,
  output logic              ctrl_wr,
  output logic              status_wr,
  output logic              pulse_wr
);

  logic cmpa_wr, cmpb_wr, ival_wr, div_wr, wdog_wr;
  logic unused_wdata;

  assign ctrl_wr   = bus_we && (bus_addr == OFF_CTRL);
  assign status_wr = bus_we && (bus_addr == OFF_STATUS);
  assign cmpa_wr   = bus_we && (bus_addr == OFF_CMPA);
  assign cmpb_wr   = bus_we && (bus_addr == OFF_CMPB);
  assign ival_wr   = bus_we && (bus_addr == OFF_IVAL);
  assign div_wr    = bus_we && (bus_addr == OFF_DIV);
  assign pulse_wr  = bus_we && (bus_addr == OFF_PULSE);
  assign wdog_wr   = bus_we && (bus_addr == OFF_WDOG);

  assign unused_wdata = ^bus_wdata[31:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl        <= '0;
      cmp_a       <= '1;
      cmp_b       <= '1;
      iv_irq_en   <= 1'b0;
      iv_zero_clr <= 1'b0;
      div_sel     <= '0;
      pa_irq_en   <= 1'b0;
      pb_irq_en   <= 1'b0;
      ff_init     <= 1'b0;
      wd_irq_en   <= 1'b0;
      wd_hold     <= 1'b0;
      wd_spare    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl.run     <= bus_wdata[7];
        ctrl.div_on  <= bus_wdata[6];
        ctrl.clr_on  <= bus_wdata[5];
        ctrl.spare3  <= bus_wdata[3];
        ctrl.ext_sel <= bus_wdata[2];
        ctrl.mode    <= tmode_e'(bus_wdata[1:0]);
      end
      if (cmpa_wr) cmp_a <= bus_wdata[CNT_W-1:0];
      if (cmpb_wr) cmp_b <= bus_wdata[CNT_W-1:0];
      if (ival_wr) begin
        iv_irq_en   <= bus_wdata[15];
        iv_zero_clr <= bus_wdata[0];
      end
      if (div_wr) div_sel <= bus_wdata[DIV_W-1:0];
      if (pulse_wr) begin
        pb_irq_en <= bus_wdata[15];
        pa_irq_en <= bus_wdata[14];
        ff_init   <= bus_wdata[0];
      end
      if (wdog_wr) begin
        wd_irq_en <= bus_wdata[15];
        wd_hold   <= bus_wdata[7];
        wd_spare  <= bus_wdata[0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL:   bus_rdata = {24'd0, ctrl.run, ctrl.div_on, ctrl.clr_on, 1'b0,
                               ctrl.spare3, ctrl.ext_sel, ctrl.mode};
      OFF_STATUS: bus_rdata = {28'd0, status};
      OFF_CMPA:   bus_rdata = 32'(cmp_a);
      OFF_CMPB:   bus_rdata = 32'(cmp_b);
      OFF_IVAL:   bus_rdata = {16'd0, iv_irq_en, 14'd0, iv_zero_clr};
      OFF_DIV:    bus_rdata = 32'(div_sel);
      OFF_PULSE:  bus_rdata = {16'd0, pb_irq_en, pa_irq_en, 13'd0, ff_init};
      OFF_WDOG:   bus_rdata = {16'd0, wd_irq_en, 7'd0, wd_hold, 6'd0, wd_spare};
      OFF_COUNT:  bus_rdata = 32'(cnt);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mode_timer24_prescale.sv
module mode_timer24_prescale
  import mode_timer24_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_tick,
  input  logic             ext_sel,
  input  logic             div_on,
  input  logic [DIV_W-1:0] div_sel,
  output logic             fire
);

  localparam int PS_W  = (1 << DIV_W) + 1;
  localparam int CFG_W = DIV_W + 2;

  logic [PS_W-1:0]  ps_q;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_moved, at_end;

  assign cfg_now   = {ext_sel, div_on, div_sel};
  assign cfg_moved = (cfg_now != cfg_q);
  assign at_end    = (ps_q == PS_W'(prescale_span(32'(div_sel)) - 1));
  assign fire      = int_tick && at_end && !cfg_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (cfg_moved)      ps_q <= '0;
      else if (fire)      ps_q <= '0;
      else if (int_tick)  ps_q <= ps_q + PS_W'(1);
    end
  end

endmodule

// File: rtl/mode_timer24_core.sv
module mode_timer24_core
  import mode_timer24_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmode_e           mode,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             iv_irq_en,
  input  logic             iv_zero_clr,
  input  logic             pa_irq_en,
  input  logic             pb_irq_en,
  input  logic             wd_irq_en,
  input  logic             wd_hold,
  input  logic             clr_req,
  input  logic             status_wr,
  input  logic             pulse_wr,
  input  logic             ff_load,
  output logic [CNT_W-1:0] cnt,
  output logic [3:0]       status,
  output logic             irq,
  output logic             ff,
  output logic             step,
  output logic [3:0]       set_vec,
  output logic             irq_evt,
  output logic             flip
);

  logic [CNT_W-1:0] nxt;
  logic             hit_a, hit_b, ev_iv, ev_pa, ev_pb, ev_wd, wrap_zero;

  assign step  = tick && mode_allows(mode, run, cnt == cmp_a, wd_hold);
  assign nxt   = cnt + CNT_W'(1);
  assign hit_a = (nxt == cmp_a);
  assign hit_b = (nxt == cmp_b);

  assign ev_iv = step && (mode == MODE_INTERVAL) && hit_a;
  assign ev_pa = step && (mode == MODE_PULSE) && hit_a;
  assign ev_pb = step && (mode == MODE_PULSE) && !hit_a && hit_b;
  assign ev_wd = step && (mode == MODE_WDOG) && hit_a;

  assign set_vec   = {ev_wd, ev_pb, ev_pa, ev_iv};
  assign flip      = ev_pa || ev_pb;
  assign wrap_zero = (ev_iv && iv_zero_clr) || ev_pb || ev_wd;
  assign irq_evt   = (ev_iv && iv_irq_en) || (ev_pa && pa_irq_en) ||
                     (ev_pb && pb_irq_en) || (ev_wd && wd_irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      status <= '0;
      irq    <= 1'b0;
      ff     <= 1'b0;
    end else begin
      if (clr_req)     cnt <= '0;
      else if (step)   cnt <= wrap_zero ? '0 : nxt;
      status <= (status_wr ? 4'd0 : status) | set_vec;
      irq    <= (irq && !status_wr) || irq_evt;
      if (pulse_wr)    ff <= ff_load;
      else if (flip)   ff <= ~ff;
    end
  end

endmodule

// File: rtl/mode_timer24.sv
module mode_timer24
  import mode_timer24_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        int_tick,
  input  logic        ext_tick,
  output logic        irq_o,
  output logic        ff_o
);

  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] cmpa_w, cmpb_w, cnt_w;
  logic [DIV_W-1:0] div_w;
  logic [3:0]       status_w, set_w;
  logic             iv_irq_en_w, iv_zclr_w, pa_en_w, pb_en_w, ff_init_w;
  logic             wd_en_w, wd_hold_w, wd_spare_w;
  logic             ctrl_wr_w, status_wr_w, pulse_wr_w;
  logic             ps_fire_w, tick_w, step_w, irq_evt_w, flip_w, clr_req_w;
  logic             unused_regs;

  assign unused_regs = ff_init_w ^ wd_spare_w ^ ctrl_w.clr_on ^ ctrl_w.spare3;

  mode_timer24_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt_w), .status(status_w),
    .ctrl(ctrl_w), .cmp_a(cmpa_w), .cmp_b(cmpb_w),
    .iv_irq_en(iv_irq_en_w), .iv_zero_clr(iv_zclr_w), .div_sel(div_w),
    .pa_irq_en(pa_en_w), .pb_irq_en(pb_en_w), .ff_init(ff_init_w),
    .wd_irq_en(wd_en_w), .wd_hold(wd_hold_w), .wd_spare(wd_spare_w),
    .bus_rdata(bus_rdata), .ctrl_wr(ctrl_wr_w), .status_wr(status_wr_w),
    .pulse_wr(pulse_wr_w)
  );

  mode_timer24_prescale #(.DIV_W(DIV_W)) ps_i (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick),
    .ext_sel(ctrl_w.ext_sel), .div_on(ctrl_w.div_on), .div_sel(div_w),
    .fire(ps_fire_w)
  );

  assign tick_w    = ctrl_w.ext_sel ? ext_tick
                                    : (ctrl_w.div_on ? ps_fire_w : int_tick);
  assign clr_req_w = ctrl_wr_w && !bus_wdata[7] && bus_wdata[5];

  mode_timer24_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_w.mode), .run(ctrl_w.run),
    .tick(tick_w), .cmp_a(cmpa_w), .cmp_b(cmpb_w),
    .iv_irq_en(iv_irq_en_w), .iv_zero_clr(iv_zclr_w),
    .pa_irq_en(pa_en_w), .pb_irq_en(pb_en_w),
    .wd_irq_en(wd_en_w), .wd_hold(wd_hold_w),
    .clr_req(clr_req_w), .status_wr(status_wr_w), .pulse_wr(pulse_wr_w),
    .ff_load(bus_wdata[0]),
    .cnt(cnt_w), .status(status_w), .irq(irq_o), .ff(ff_o),
    .step(step_w), .set_vec(set_w), .irq_evt(irq_evt_w), .flip(flip_w)
  );

endmodule

// File: rtl/mode_timer24_chk.sv
module mode_timer24_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [3:0]       status,
  input logic             irq,
  input logic             ff,
  input logic             ctrl_wr,
  input logic [7:0]       ctrl_data,
  input logic             status_wr,
  input logic             pulse_wr,
  input logic [3:0]       set_vec,
  input logic             irq_evt,
  input logic             flip
);

  // R3
  off_mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !ctrl_wr) |=> (cnt == $past(cnt)));

  // R6
  interval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && cnt == cmp_a && !ctrl_wr) |=> (cnt == $past(cnt)));

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && set_vec == 4'd0 && !irq_evt) |=> (status == 4'd0 && !irq));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !status_wr) |=> irq);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_evt));

  // R11
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_data[7] && ctrl_data[5]) |=> (cnt == '0));

  // R7
  ff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && !pulse_wr) |=> $stable(ff));

endmodule

bind mode_timer24 mode_timer24_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(ctrl_w.mode), .cnt(cnt_w), .cmp_a(cmpa_w),
  .status(status_w), .irq(irq_o), .ff(ff_o), .ctrl_wr(ctrl_wr_w),
  .ctrl_data(bus_wdata[7:0]), .status_wr(status_wr_w), .pulse_wr(pulse_wr_w),
  .set_vec(set_w), .irq_evt(irq_evt_w), .flip(flip_w)
);

// File: tb/mode_timer24_tb.sv
module mode_timer24_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'hF0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        int_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic        irq_o, ff_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mode_timer24 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_tick(int_tick),
    .ext_tick(ext_tick), .irq_o(irq_o), .ff_o(ff_o)
  );

  // behavioural reference state
  int m_ctrl, m_status, m_cmpa, m_cmpb, m_ival, m_div, m_pulse, m_wdog;
  int m_cnt, m_irq, m_ff, m_ps, m_cfg_prev;

  task automatic m_reset();
    m_ctrl = 0; m_status = 0; m_cmpa = 'hFFFFFF; m_cmpb = 'hFFFFFF;
    m_ival = 0; m_div = 0; m_pulse = 0; m_wdog = 0;
    m_cnt = 0; m_irq = 0; m_ff = 0; m_ps = 0; m_cfg_prev = 0;
  endtask

  function automatic int m_read(input int a);
    case (a)
      'h00: return m_ctrl;
      'h04: return m_status;
      'h08: return m_cmpa;
      'h0C: return m_cmpb;
      'h10: return m_ival;
      'h20: return m_div;
      'h30: return m_pulse;
      'h40: return m_wdog;
      'hF0: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic m_step();
    int cfg, mode, fire, tick, go, target, ev_a, ev_b, flag, raise;
    bit clr_status;
    cfg = (m_ctrl & 'h44) * 8 + m_div;
    fire = 0;
    if (cfg != m_cfg_prev) m_ps = 0;
    else if (int_tick) begin
      m_ps++;
      if (m_ps >= (2 ** (m_div + 1))) begin m_ps = 0; fire = 1; end
    end
    m_cfg_prev = cfg;
    if (m_ctrl & 'h04) tick = ext_tick;
    else if (m_ctrl & 'h40) tick = fire;
    else tick = int_tick;
    mode = m_ctrl & 3;
    case (mode)
      0: go = (m_ctrl >> 7) & (m_cnt != m_cmpa);
      1: go = (m_ctrl >> 7) & 1;
      2: go = ((m_ctrl >> 7) & 1) | !((m_wdog >> 7) & 1);
      default: go = 0;
    endcase
    go = go & tick;
    flag = 0; raise = 0;
    clr_status = bus_we && bus_addr == 8'h04;
    if (clr_status) begin m_status = 0; m_irq = 0; end
    if (go) begin
      target = (m_cnt + 1) % (1 << 24);
      ev_a = (target == m_cmpa);
      ev_b = (target == m_cmpb);
      if (mode == 0 && ev_a) begin
        flag = 1; raise = (m_ival >> 15) & 1;
        if (m_ival & 1) target = 0;
      end else if (mode == 1 && ev_a) begin
        flag = 2; raise = (m_pulse >> 14) & 1; m_ff = 1 - m_ff;
      end else if (mode == 1 && ev_b) begin
        flag = 4; raise = (m_pulse >> 15) & 1; m_ff = 1 - m_ff; target = 0;
      end else if (mode == 2 && ev_a) begin
        flag = 8; raise = (m_wdog >> 15) & 1; target = 0;
      end
      m_cnt = target;
    end
    m_status = m_status | flag;
    if (raise) m_irq = 1;
    if (bus_we) begin
      case (bus_addr)
        8'h00: begin
          m_ctrl = bus_wdata & 'hEF;
          if ((bus_wdata & 'hA0) == 'h20) m_cnt = 0;
        end
        8'h08: m_cmpa = bus_wdata & 'hFFFFFF;
        8'h0C: m_cmpb = bus_wdata & 'hFFFFFF;
        8'h10: m_ival = bus_wdata & 'h8001;
        8'h20: m_div  = bus_wdata & 7;
        8'h30: begin m_pulse = bus_wdata & 'hC001; m_ff = bus_wdata & 1; end
        8'h40: m_wdog = bus_wdata & 'h8081;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // model advance at each edge, compare a quarter period later
  always begin
    @(posedge clk);
    if (!rst_n) m_reset(); else m_step();
    #5;
    if (rst_n && !done) begin
      check("R2 read data vs model", int'(bus_rdata), m_read(int'(bus_addr)));
      check("R10 interrupt vs model", int'(irq_o), m_irq);
      check("R7 flip-flop vs model", int'(ff_o), m_ff);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hF0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 8'(a);
    #2;
    v = int'(bus_rdata);
    bus_addr = 8'hF0;
  endtask

  task automatic pulse_int(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); int_tick = 1'b1;
      @(negedge clk); int_tick = 1'b0;
    end
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1'b1; int_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0; int_tick = 1'b0;
    end
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd('h08, v); check("R1 compare A reset", v, 'hFFFFFF);
    rd('h0C, v); check("R1 compare B reset", v, 'hFFFFFF);
    rd('h00, v); check("R1 control reset", v, 0);
    rd('hF0, v); check("R1 counter reset", v, 0);
    check("R1 irq reset", int'(irq_o), 0);
    check("R1 ff reset", int'(ff_o), 0);
    // R2 map details
    wr('h00, 'h13); rd('h00, v); check("R2 control bit4 reads zero", v, 'h03);
    wr('h08, 'hABCDEF12); rd('h08, v); check("R2 compare keeps 24 bits", v, 'hCDEF12);
    rd('h50, v); check("R2 unmapped reads zero", v, 0);
    // R3 off mode and run gate
    wr('h00, 'h83); pulse_int(10); rd('hF0, v); check("R3 off mode frozen", v, 0);
    wr('h00, 'h00); pulse_int(4); rd('hF0, v); check("R3 run low holds", v, 0);
    // R5 interval with zero clear
    wr('h08, 5); wr('h10, 'h8001); wr('h00, 'h80);
    pulse_int(5);
    rd('hF0, v); check("R5 zero clear at A", v, 0);
    rd('h04, v); check("R5 interval flag", v, 1);
    check("R5 interval irq", int'(irq_o), 1);
    pulse_int(2); rd('hF0, v); check("R5 counts on", v, 2);
    // R10 status clear
    wr('h04, 0); rd('h04, v); check("R10 status cleared", v, 0);
    check("R10 irq lowered", int'(irq_o), 0);
    // R11 control clear, R6 hold
    wr('h00, 'h20); rd('hF0, v); check("R11 control clear", v, 0);
    wr('h10, 'h8000); wr('h00, 'h80);
    pulse_int(5); rd('hF0, v); check("R6 reaches A", v, 5);
    check("R6 irq on arrival", int'(irq_o), 1);
    wr('h04, 0); pulse_int(3);
    rd('hF0, v); check("R6 holds at A", v, 5);
    check("R6 no repeat irq", int'(irq_o), 0);
    rd('h04, v); check("R6 no repeat flag", v, 0);
    // R4 prescaler and external source
    wr('h00, 'h20); wr('h08, 'hFFFFFF); wr('h20, 1); wr('h00, 'hC0);
    pulse_int(8); rd('hF0, v); check("R4 divide by four", v, 2);
    wr('h00, 'h84); pulse_ext(3); rd('hF0, v); check("R4 external undivided", v, 5);
    // R13 prescaler restart on ratio change
    wr('h00, 'h20); wr('h00, 'hC0); pulse_int(3);
    wr('h20, 0); pulse_int(2); rd('hF0, v); check("R13 restart after change", v, 1);
    pulse_int(1); rd('hF0, v); check("R13 half step pending", v, 1);
    // R7 R8 pulse generator
    wr('h00, 'h20); wr('h04, 0); wr('h30, 'h4000);
    wr('h08, 3); wr('h0C, 6); wr('h00, 'h81);
    pulse_int(3);
    check("R7 ff toggles at A", int'(ff_o), 1);
    rd('h04, v); check("R7 pulse A flag", v, 2);
    check("R8 A irq enabled", int'(irq_o), 1);
    wr('h04, 0); pulse_int(3);
    check("R7 ff toggles at B", int'(ff_o), 0);
    rd('h04, v); check("R7 pulse B flag", v, 4);
    rd('hF0, v); check("R7 clear at B", v, 0);
    check("R8 B irq disabled", int'(irq_o), 0);
    // R12 preset flip-flop
    wr('h30, 1); check("R12 ff preset", int'(ff_o), 1);
    // R9 watchdog
    wr('h00, 'h20); wr('h04, 0); wr('h40, 'h8000); wr('h08, 4); wr('h00, 'h02);
    pulse_int(4);
    rd('h04, v); check("R9 watchdog flag", v, 8);
    check("R9 watchdog irq", int'(irq_o), 1);
    rd('hF0, v); check("R9 watchdog clear", v, 0);
    wr('h04, 0); wr('h40, 'h8080); pulse_int(3);
    rd('hF0, v); check("R9 stop bit holds", v, 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule